// File: doc/BRIEF.md
# Bootstrap Mailbox Command Sequencer

This block handles the early boot handshake of a secure coprocessor. Requests arrive as 64-bit mailbox messages on a valid/ready stream. Only messages addressed to the bootstrap endpoint are served. The block answers status pings, builds a nonce from a stream of random words and returns that nonce one word at a time. It also carries out the continue-boot command, which moves the coprocessor into its next boot stage.

When continue-boot arrives, the sequencer does not trust the requester. It samples a hardware lock flag for the protected memory region. If the flag is set, it latches the region base and size and acknowledges the command. Once that acknowledgement is taken, it raises a stage-done output and stops serving commands. If the flag is clear, the sequencer halts for good: it sends no reply and accepts nothing more until reset.

Every message is split into fields by bit position. The endpoint sits in bits 7:0, the tag in 15:8, the opcode in 23:16, a parameter or status byte in 31:24 and a 32-bit data word in 63:32. The sequencer takes at most one request at a time. The request channel stalls while a reply is waiting or a nonce is being gathered. A pending reply holds still until the consumer takes it.

Top module: `boot_mbox_seq`

## Requirements
- R1: A request whose endpoint field (bits 7:0) is not 255 is accepted and discarded, and produces no reply.
- R2: Every reply copies the request's endpoint, tag and opcode into bits 7:0, 15:8 and 23:16. It puts a status code in bits 31:24 (0 ok, 1 no nonce yet, 2 unknown opcode, 3 bad word index) and its result in bits 63:32.
- R3: Opcodes 1 and 2 (ping) get status 0 and data 0.
- R4: Opcode 3 pulls two words from the random stream, in order, into nonce word 0 and then word 1. Its reply (status 0, data 0) is sent only after both words have been taken.
- R5: Opcode 4 returns nonce word 0 when the parameter byte is 0 and word 1 when it is 1, with status 0. Any larger parameter gets status 3 and data 0.
- R6: Opcode 4 before any nonce has been generated since reset gets status 1 and data 0.
- R7: Any opcode other than 1 to 5 gets status 2 and data 0.
- R8: Opcode 5 with the lock flag high captures the region base and size at acceptance and replies with status 0. Once that reply is taken, stage_done rises and stays high with the captured values, and req_ready stays low.
- R9: Opcode 5 with the lock flag low produces no reply. It raises halted, and req_ready stays low until reset.
- R10: While a reply waits with rsp_ready low, rsp_valid and rsp_msg hold steady. req_ready is low while a reply is pending or a nonce is being gathered.
- R11: After reset, req_ready is 1 and rsp_valid, stage_done and halted are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_msg | input | 64 | Request message |
| rsp_valid | output | 1 | Reply message valid |
| rsp_ready | input | 1 | Consumer takes the reply |
| rsp_msg | output | 64 | Reply message |
| rnd_valid | input | 1 | Random word valid |
| rnd_ready | output | 1 | Sequencer takes a random word |
| rnd_data | input | 32 | Random word |
| lock_ok | input | 1 | Protected-region lock status |
| rgn_base | input | ADDR_W (40) | Protected-region base address |
| rgn_size | input | SIZE_W (32) | Protected-region size |
| stage_done | output | 1 | Handshake finished, next stage may run |
| stage_base | output | ADDR_W (40) | Captured region base |
| stage_size | output | SIZE_W (32) | Captured region size |
| halted | output | 1 | Lock check failed, sequencer stopped |

## Verification
The bench builds the block with its default parameters: a two-word nonce, endpoint 255, a 40-bit base and a 32-bit size. With two nonce words, a parameter byte of 2 is the first out-of-range index, so the bad-index status can be reached. Back-pressure patterns on the random stream and on the reply channel, with differing periods, stretch nonce gathering and hold replies across stalls. A mid-run reset brings both continue-boot outcomes within reach in a single run, along with the no-nonce status that follows a reset.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  localparam int MSG_W = 64;

  typedef struct packed {
    logic [31:0] data;
    logic [7:0]  param;
    logic [7:0]  opcode;
    logic [7:0]  tag;
    logic [7:0]  ep;
  } bmb_msg_t;

  typedef enum logic [2:0] {CMD_PING, CMD_GEN, CMD_GET, CMD_CONT, CMD_BAD} bmb_cmd_e;

  localparam logic [7:0] ST_OK       = 8'd0;
  localparam logic [7:0] ST_NO_NONCE = 8'd1;
  localparam logic [7:0] ST_BAD_OP   = 8'd2;
  localparam logic [7:0] ST_BAD_IDX  = 8'd3;

  function automatic bmb_msg_t bmb_reply(bmb_msg_t rq, logic [7:0] st, logic [31:0] d);
    bmb_msg_t r;
    r        = rq;
    r.param  = st;
    r.data   = d;
    return r;
  endfunction
endpackage

// File: rtl/bmb_decode.sv
module bmb_decode
  import bmb_pkg::*;
#(
  parameter logic [7:0] BOOT_EP = 8'hFF
) (
  input  bmb_msg_t msg,
  output logic     for_us,
  output bmb_cmd_e cmd
);
  assign for_us = (msg.ep == BOOT_EP);

  always_comb begin
    unique case (msg.opcode)
      8'd1, 8'd2: cmd = CMD_PING;
      8'd3:       cmd = CMD_GEN;
      8'd4:       cmd = CMD_GET;
      8'd5:       cmd = CMD_CONT;
      default:    cmd = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/bmb_nonce.sv
module bmb_nonce #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rnd_valid,
  input  logic [WORD_W-1:0] rnd_data,
  output logic              rnd_ready,
  output logic              done,
  output logic              have,
  input  logic [7:0]        sel,
  output logic              sel_ok,
  output logic [WORD_W-1:0] word
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic [IDX_W-1:0] idx;
  logic busy;
  logic take;

  assign rnd_ready = busy;
  assign take      = busy && rnd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      have <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
        have <= 1'b0;
      end else if (take) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          have <= 1'b1;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (take && idx == IDX_W'(g)) words[g] <= rnd_data;
    end
  end

  assign sel_ok = (32'(sel) < NWORDS);
  assign word   = sel_ok ? words[sel[IDX_W-1:0]] : '0;

  AST_RND_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rnd_ready) else $error("nonce still drawing after done"); // R4
endmodule

// File: rtl/boot_mbox_seq.sv
module boot_mbox_seq
  import bmb_pkg::*;
#(
  parameter logic [7:0] BOOT_EP = 8'hFF,
  parameter int ADDR_W      = 40,
  parameter int SIZE_W      = 32,
  parameter int NONCE_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MSG_W-1:0]  req_msg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [MSG_W-1:0]  rsp_msg,
  input  logic              rnd_valid,
  output logic              rnd_ready,
  input  logic [31:0]       rnd_data,
  input  logic              lock_ok,
  input  logic [ADDR_W-1:0] rgn_base,
  input  logic [SIZE_W-1:0] rgn_size,
  output logic              stage_done,
  output logic [ADDR_W-1:0] stage_base,
  output logic [SIZE_W-1:0] stage_size,
  output logic              halted
);
  typedef enum logic [2:0] {S_IDLE, S_GEN, S_RSP, S_DONE, S_HALT} state_e;

  state_e   state;
  bmb_msg_t req_s, hdr_q, rsp_q;
  bmb_cmd_e cmd;
  logic     for_us, fin_q, accept;
  logic     n_start, n_done, n_have, n_sel_ok;
  logic [31:0] n_word;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;

  assign req_s  = req_msg;
  assign accept = req_valid && req_ready;

  bmb_decode #(.BOOT_EP(BOOT_EP)) u_dec (
    .msg(req_s), .for_us(for_us), .cmd(cmd)
  );

  assign n_start = accept && for_us && (cmd == CMD_GEN);

  bmb_nonce #(.WORD_W(32), .NWORDS(NONCE_WORDS)) u_nonce (
    .clk(clk), .rst_n(rst_n), .start(n_start),
    .rnd_valid(rnd_valid), .rnd_data(rnd_data), .rnd_ready(rnd_ready),
    .done(n_done), .have(n_have), .sel(req_s.param),
    .sel_ok(n_sel_ok), .word(n_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hdr_q  <= '0;
      rsp_q  <= '0;
      base_q <= '0;
      size_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept && for_us) begin
          hdr_q <= req_s;
          unique case (cmd)
            CMD_PING: begin
              rsp_q <= bmb_reply(req_s, ST_OK, 32'd0);
              state <= S_RSP;
            end
            CMD_GEN: state <= S_GEN;
            CMD_GET: begin
              if (!n_have)         rsp_q <= bmb_reply(req_s, ST_NO_NONCE, 32'd0);
              else if (!n_sel_ok)  rsp_q <= bmb_reply(req_s, ST_BAD_IDX, 32'd0);
              else                 rsp_q <= bmb_reply(req_s, ST_OK, n_word);
              state <= S_RSP;
            end
            CMD_CONT: begin
              if (lock_ok) begin
                base_q <= rgn_base;
                size_q <= rgn_size;
                fin_q  <= 1'b1;
                rsp_q  <= bmb_reply(req_s, ST_OK, 32'd0);
                state  <= S_RSP;
              end else begin
                state <= S_HALT;
              end
            end
            default: begin
              rsp_q <= bmb_reply(req_s, ST_BAD_OP, 32'd0);
              state <= S_RSP;
            end
          endcase
        end
        S_GEN: if (n_done) begin
          rsp_q <= bmb_reply(hdr_q, ST_OK, 32'd0);
          state <= S_RSP;
        end
        S_RSP: if (rsp_ready) state <= fin_q ? S_DONE : S_IDLE;
        S_DONE: state <= S_DONE;
        default: state <= S_HALT;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_RSP);
  assign rsp_msg    = rsp_q;
  assign stage_done = (state == S_DONE);
  assign stage_base = base_q;
  assign stage_size = size_q;
  assign halted     = (state == S_HALT);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_msg)) else $error("reply moved under stall"); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || rnd_ready) |-> !req_ready) else $error("request taken while busy"); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !rsp_valid) else $error("left halt"); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |=> stage_done && $stable(stage_base) && $stable(stage_size)) else $error("stage outputs moved"); // R8
  AST_NO_DONE_WITHOUT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !stage_done) else $error("halt with done"); // R9
endmodule

// File: tb/boot_mbox_seq_tb.sv
module boot_mbox_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_msg = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_msg;
  logic        rnd_valid = 1'b0;
  logic        rnd_ready;
  logic [31:0] rnd_data;
  logic        lock_ok = 1'b0;
  logic [39:0] rgn_base = '0;
  logic [31:0] rgn_size = '0;
  logic        stage_done;
  logic [39:0] stage_base;
  logic [31:0] stage_size;
  logic        halted;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int k_src = 0;
  int k_mdl = 0;
  logic rnd_fire = 1'b0;
  logic [31:0] n0, n1;
  logic [63:0] expq[$];

  always #5 clk = ~clk;

  boot_mbox_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_msg(req_msg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_msg(rsp_msg), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .rnd_data(rnd_data), .lock_ok(lock_ok), .rgn_base(rgn_base),
    .rgn_size(rgn_size), .stage_done(stage_done), .stage_base(stage_base),
    .stage_size(stage_size), .halted(halted)
  );

  function automatic logic [31:0] rnd_val(int k);
    return 32'hC0DE0000 + 32'(k) * 32'h00011111;
  endfunction

  assign rnd_data = rnd_val(k_src);

  always @(negedge clk) rnd_fire <= rnd_valid && rnd_ready;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rnd_fire) k_src++;
    rnd_valid = (cyc % 3) != 0;
    rsp_ready = (cyc % 5) != 1 && (cyc % 5) != 2;
  end

  function automatic logic [63:0] mk(logic [7:0] ep, logic [7:0] tag, logic [7:0] op,
                                     logic [7:0] prm, logic [31:0] d);
    return {d, prm, op, tag, ep};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) chk("R1 unexpected reply", rsp_msg, 64'hX);
      else chk("R2 reply", rsp_msg, expq.pop_front());
    end
  end

  task automatic send(logic [7:0] ep, logic [7:0] tag, logic [7:0] op, logic [7:0] prm,
                      bit has_rsp, logic [7:0] st, logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (has_rsp) expq.push_back(mk(ep, tag, op, st, d));
    req_msg   = mk(ep, tag, op, prm, 32'hDEAD0000 ^ 32'(tag));
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs", {60'd0, req_ready, rsp_valid, stage_done, halted}, {60'd0, 4'b1000});

    send(8'hFF, 8'h10, 8'd4, 8'd0, 1, 8'd1, 32'd0);       // R6
    send(8'hFF, 8'h11, 8'd1, 8'd0, 1, 8'd0, 32'd0);       // R3
    send(8'hFF, 8'h12, 8'd2, 8'h55, 1, 8'd0, 32'd0);      // R3
    send(8'hFF, 8'h13, 8'd9, 8'd0, 1, 8'd2, 32'd0);       // R7
    send(8'hFF, 8'h14, 8'd0, 8'd0, 1, 8'd2, 32'd0);       // R7
    drain();
    send(8'h12, 8'h15, 8'd1, 8'd0, 0, 8'd0, 32'd0);       // R1
    repeat (8) @(negedge clk);
    chk("R1 dropped message no reply", {63'd0, rsp_valid}, 64'd0);

    n0 = rnd_val(k_mdl); n1 = rnd_val(k_mdl + 1); k_mdl += 2;
    send(8'hFF, 8'h20, 8'd3, 8'd0, 1, 8'd0, 32'd0);       // R4
    send(8'hFF, 8'h21, 8'd4, 8'd0, 1, 8'd0, n0);          // R5
    send(8'hFF, 8'h22, 8'd4, 8'd1, 1, 8'd0, n1);          // R5
    send(8'hFF, 8'h23, 8'd4, 8'd2, 1, 8'd3, 32'd0);       // R5 bad index
    drain();
    n0 = rnd_val(k_mdl); n1 = rnd_val(k_mdl + 1); k_mdl += 2;
    send(8'hFF, 8'h24, 8'd3, 8'd0, 1, 8'd0, 32'd0);       // R4 fresh nonce
    send(8'hFF, 8'h25, 8'd4, 8'd1, 1, 8'd0, n1);          // R5
    send(8'hFF, 8'h26, 8'd4, 8'd0, 1, 8'd0, n0);          // R5
    drain();

    lock_ok  = 1'b1;
    rgn_base = 40'h12_3456_7000;
    rgn_size = 32'h0040_0000;
    send(8'hFF, 8'h30, 8'd5, 8'd0, 1, 8'd0, 32'd0);       // R8
    rgn_base = 40'hFF_FFFF_F000;
    rgn_size = 32'h1;
    drain();
    chk("R8 stage_done", {63'd0, stage_done}, 64'd1);
    chk("R8 captured base", {24'd0, stage_base}, {24'd0, 40'h12_3456_7000});
    chk("R8 captured size", {32'd0, stage_size}, {32'd0, 32'h0040_0000});
    repeat (10) @(negedge clk);
    chk("R8 no further accept", {62'd0, req_ready, halted}, 64'd0);

    do_reset();
    @(negedge clk);
    chk("R11 reset after done", {60'd0, req_ready, rsp_valid, stage_done, halted}, {60'd0, 4'b1000});
    send(8'hFF, 8'h40, 8'd4, 8'd1, 1, 8'd1, 32'd0);       // R6 after reset
    drain();
    lock_ok = 1'b0;
    send(8'hFF, 8'h41, 8'd5, 8'd0, 0, 8'd0, 32'd0);       // R9
    repeat (20) @(negedge clk);
    chk("R9 halted no reply no accept",
        {60'd0, halted, req_ready, rsp_valid, stage_done}, {60'd0, 4'b1000});
    lock_ok = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 halt persists", {63'd0, halted}, 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule